// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps an 8-bit status byte that tells firmware why the processor last restarted or woke up. Each kind of reset or wake-up arrives as a single-cycle event input. Each kind of event changes its own small set of flag bits and leaves the others as they were, so software can read the byte and work out what happened. Most flags are active-low. Software re-arms them by writing through a byte-wide processor write port. Two extra sticky flags record stack overflow and stack underflow resets.

Along with the flags, the block reports how execution resumes after each event: from the reset vector, at the next instruction (PC+2), or at one of two interrupt vectors. This action appears on registered outputs one cycle after the event. The program counter and the stack themselves belong to other blocks. If several events arrive in the same cycle, a fixed priority picks the one that applies. Any event in a cycle makes the block drop a processor write in that same cycle.

Top module: `rcs_reset_cause`

## Requirements
- R1: An active-low asynchronous reset, and likewise a power-on event, loads the status byte with 8'h1C and clears both stack flags. The reset makes the resume action NONE. The power-on event makes it RESET.
- R2: Status bit positions: bit 7 is the interrupt-priority enable, bits 6 and 5 always read 0, bit 4 is the software-reset flag, bit 3 is the time-out flag, bit 2 is the power-down flag, bit 1 is the power-on flag and bit 0 is the brown-out flag. With no event and no write, the byte holds its value.
- R3: A brown-out event sets bits 4, 3 and 2 to 1 and clears bits 0 and 7. Bit 1 keeps its value.
- R4: A software-reset event clears bit 4 and bit 7 and keeps bits 3 to 0. A pin reset while awake clears bit 7 and keeps all flags.
- R5: A pin reset during sleep clears bit 7, sets bit 3 and clears bit 2. A watchdog reset clears bit 3, sets bit 2 and keeps bit 7.
- R6: A watchdog wake-up clears bits 3 and 2, keeps bit 7 and gives resume action NEXT. An interrupt wake-up also clears bits 3 and 2 and keeps bit 7.
- R7: A stack-full or stack-underflow event sets its own sticky flag, clears bit 7 and keeps bits 4 to 0. Only a power-on event or the reset clears the sticky flags.
- R8: The resume action is encoded 0 NONE, 1 RESET, 2 NEXT, 3 VECTOR and is valid the cycle after the event. Every true reset gives RESET. An interrupt wake-up gives VECTOR when the global-enable input is 1, and NEXT when it is 0. In VECTOR, vec_addr is 0x08 if int_high is 1 and 0x18 if it is 0. vec_addr is 0 otherwise.
- R9: The sleep-instruction input sets bit 3 and clears bit 2. The watchdog-clear input sets both bits. Neither one gives a resume action.
- R10: A processor write updates bits 7, 4, 1 and 0 from wr_data. Bits 6, 5, 3 and 2 ignore the write.
- R11: When any event or instruction input is active in the same cycle as a write, the write is discarded completely.
- R12: When several inputs are active together, only the highest applies. The order, highest first, is: power-on, brown-out, watchdog reset, pin reset in sleep, pin reset awake, software reset, stack full, stack underflow, watchdog wake-up, interrupt wake-up, watchdog clear, sleep instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_ev | input | 1 | Power-on event |
| bor_ev | input | 1 | Brown-out event |
| wdt_rst_ev | input | 1 | Watchdog reset event |
| pin_sleep_ev | input | 1 | External pin reset while asleep |
| pin_run_ev | input | 1 | External pin reset while awake |
| swrst_ev | input | 1 | Software reset instruction |
| stk_full_ev | input | 1 | Stack overflow reset |
| stk_under_ev | input | 1 | Stack underflow reset |
| wdt_wake_ev | input | 1 | Watchdog wake-up from sleep |
| int_wake_ev | input | 1 | Interrupt wake-up from sleep |
| wdt_clr_ev | input | 1 | Watchdog clear instruction |
| sleep_ev | input | 1 | Sleep instruction |
| gie_set | input | 1 | A global interrupt enable is set |
| int_high | input | 1 | Waking interrupt has high priority |
| wr_en | input | 1 | Processor write strobe |
| wr_data | input | 8 | Processor write data |
| status | output | 8 | Status byte |
| stk_full_flag | output | 1 | Sticky stack overflow flag |
| stk_under_flag | output | 1 | Sticky stack underflow flag |
| pc_act | output | 2 | Resume action for the last cycle |
| vec_addr | output | VEC_W | Interrupt vector for VECTOR action |

## Verification
Two things can land in the same cycle: an event and a processor write, and also two different events. The bench raises both cases on purpose, with directed writes of all-ones and all-zeros alongside an instruction input, and with two events whose priority is known. It also mixes these collisions into a seeded random stream. Its model applies only the top-priority input and throws the write away. It judges the outcome at the ports by comparing the byte, the sticky flags and the resume action on the cycle after.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

    localparam int N_EV = 12;
    localparam int EV_W = 4;
    localparam int ST_W = 8;

    // Priority order: lower index wins
    typedef enum logic [EV_W-1:0] {
        EV_POR       = 4'd0,
        EV_BOR       = 4'd1,
        EV_WDT_RST   = 4'd2,
        EV_PIN_SLEEP = 4'd3,
        EV_PIN_RUN   = 4'd4,
        EV_SWRST     = 4'd5,
        EV_STK_FULL  = 4'd6,
        EV_STK_UNDER = 4'd7,
        EV_WDT_WAKE  = 4'd8,
        EV_INT_WAKE  = 4'd9,
        EV_WDT_CLR   = 4'd10,
        EV_SLEEP     = 4'd11,
        EV_NONE      = 4'd12
    } ev_e;

    typedef enum logic [1:0] {
        PC_NONE   = 2'd0,
        PC_RESET  = 2'd1,
        PC_NEXT   = 2'd2,
        PC_VECTOR = 2'd3
    } pc_act_e;

    localparam int B_IPEN = 7;
    localparam int B_SWR  = 4;
    localparam int B_TO   = 3;
    localparam int B_PD   = 2;
    localparam int B_PON  = 1;
    localparam int B_BRN  = 0;

    localparam logic [ST_W-1:0] PON_VALUE = 8'h1C;
    localparam logic [ST_W-1:0] WR_MASK   = 8'h93;
    localparam logic [ST_W-1:0] IMPL_MASK = 8'h9F;

    typedef struct packed {
        logic [ST_W-1:0] status;
        logic            stk_full;
        logic            stk_under;
        pc_act_e         pc_act;
        logic            vec_hi;
    } rcs_state_t;

    localparam rcs_state_t STATE_RESET = '{
        status:    PON_VALUE,
        stk_full:  1'b0,
        stk_under: 1'b0,
        pc_act:    PC_NONE,
        vec_hi:    1'b0
    };

endpackage

// File: rtl/rcs_event_select.sv
module rcs_event_select
    import rcs_pkg::*;
(
    input  logic [N_EV-1:0] ev_vec,
    output ev_e             sel
);
    always_comb begin
        sel = EV_NONE;
        for (int i = N_EV - 1; i >= 0; i--) begin
            if (ev_vec[i]) begin
                sel = ev_e'(i[EV_W-1:0]);
            end
        end
    end
endmodule

// File: rtl/rcs_flag_update.sv
module rcs_flag_update
    import rcs_pkg::*;
(
    input  ev_e             sel,
    input  logic [ST_W-1:0] status_q,
    input  logic            stk_full_q,
    input  logic            stk_under_q,
    input  logic            wr_en,
    input  logic [ST_W-1:0] wr_data,
    output logic [ST_W-1:0] status_nx,
    output logic            stk_full_nx,
    output logic            stk_under_nx
);
    always_comb begin
        status_nx    = status_q;
        stk_full_nx  = stk_full_q;
        stk_under_nx = stk_under_q;
        case (sel)
            EV_POR: begin
                status_nx    = PON_VALUE;
                stk_full_nx  = 1'b0;
                stk_under_nx = 1'b0;
            end
            EV_BOR: begin
                status_nx[B_IPEN] = 1'b0;
                status_nx[B_SWR]  = 1'b1;
                status_nx[B_TO]   = 1'b1;
                status_nx[B_PD]   = 1'b1;
                status_nx[B_BRN]  = 1'b0;
            end
            EV_WDT_RST: begin
                status_nx[B_TO] = 1'b0;
                status_nx[B_PD] = 1'b1;
            end
            EV_PIN_SLEEP: begin
                status_nx[B_IPEN] = 1'b0;
                status_nx[B_TO]   = 1'b1;
                status_nx[B_PD]   = 1'b0;
            end
            EV_PIN_RUN: begin
                status_nx[B_IPEN] = 1'b0;
            end
            EV_SWRST: begin
                status_nx[B_IPEN] = 1'b0;
                status_nx[B_SWR]  = 1'b0;
            end
            EV_STK_FULL: begin
                status_nx[B_IPEN] = 1'b0;
                stk_full_nx       = 1'b1;
            end
            EV_STK_UNDER: begin
                status_nx[B_IPEN] = 1'b0;
                stk_under_nx      = 1'b1;
            end
            EV_WDT_WAKE, EV_INT_WAKE: begin
                status_nx[B_TO] = 1'b0;
                status_nx[B_PD] = 1'b0;
            end
            EV_WDT_CLR: begin
                status_nx[B_TO] = 1'b1;
                status_nx[B_PD] = 1'b1;
            end
            EV_SLEEP: begin
                status_nx[B_TO] = 1'b1;
                status_nx[B_PD] = 1'b0;
            end
            default: begin
                if (wr_en) begin
                    status_nx = (status_q & ~WR_MASK) | (wr_data & WR_MASK);
                end
            end
        endcase
        status_nx = status_nx & IMPL_MASK;
    end
endmodule

// File: rtl/rcs_resume_ctrl.sv
module rcs_resume_ctrl
    import rcs_pkg::*;
(
    input  ev_e     sel,
    input  logic    gie_set,
    input  logic    int_high,
    output pc_act_e act_nx,
    output logic    vec_hi_nx
);
    always_comb begin
        act_nx    = PC_NONE;
        vec_hi_nx = 1'b0;
        case (sel)
            EV_POR, EV_BOR, EV_WDT_RST, EV_PIN_SLEEP, EV_PIN_RUN,
            EV_SWRST, EV_STK_FULL, EV_STK_UNDER: act_nx = PC_RESET;
            EV_WDT_WAKE: act_nx = PC_NEXT;
            EV_INT_WAKE: begin
                if (gie_set) begin
                    act_nx    = PC_VECTOR;
                    vec_hi_nx = int_high;
                end else begin
                    act_nx = PC_NEXT;
                end
            end
            default: act_nx = PC_NONE;
        endcase
    end
endmodule

// File: rtl/rcs_reset_cause.sv
module rcs_reset_cause
    import rcs_pkg::*;
#(
    parameter int              VEC_W  = 21,
    parameter logic [VEC_W-1:0] HI_VEC = 21'h000008,
    parameter logic [VEC_W-1:0] LO_VEC = 21'h000018
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             por_ev,
    input  logic             bor_ev,
    input  logic             wdt_rst_ev,
    input  logic             pin_sleep_ev,
    input  logic             pin_run_ev,
    input  logic             swrst_ev,
    input  logic             stk_full_ev,
    input  logic             stk_under_ev,
    input  logic             wdt_wake_ev,
    input  logic             int_wake_ev,
    input  logic             wdt_clr_ev,
    input  logic             sleep_ev,
    input  logic             gie_set,
    input  logic             int_high,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    output logic [7:0]       status,
    output logic             stk_full_flag,
    output logic             stk_under_flag,
    output logic [1:0]       pc_act,
    output logic [VEC_W-1:0] vec_addr
);
    rcs_state_t state_d, state_q;

    logic [N_EV-1:0] ev_vec;
    ev_e             sel;
    logic [ST_W-1:0] status_nx;
    logic            stk_full_nx;
    logic            stk_under_nx;
    pc_act_e         act_nx;
    logic            vec_hi_nx;

    assign ev_vec = {sleep_ev, wdt_clr_ev, int_wake_ev, wdt_wake_ev,
                     stk_under_ev, stk_full_ev, swrst_ev, pin_run_ev,
                     pin_sleep_ev, wdt_rst_ev, bor_ev, por_ev};

    rcs_event_select u_sel (
        .ev_vec (ev_vec),
        .sel    (sel)
    );

    rcs_flag_update u_flags (
        .sel          (sel),
        .status_q     (state_q.status),
        .stk_full_q   (state_q.stk_full),
        .stk_under_q  (state_q.stk_under),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .status_nx    (status_nx),
        .stk_full_nx  (stk_full_nx),
        .stk_under_nx (stk_under_nx)
    );

    rcs_resume_ctrl u_resume (
        .sel       (sel),
        .gie_set   (gie_set),
        .int_high  (int_high),
        .act_nx    (act_nx),
        .vec_hi_nx (vec_hi_nx)
    );

    always_comb begin
        state_d           = state_q;
        state_d.status    = status_nx;
        state_d.stk_full  = stk_full_nx;
        state_d.stk_under = stk_under_nx;
        state_d.pc_act    = act_nx;
        state_d.vec_hi    = vec_hi_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= STATE_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    assign status         = state_q.status;
    assign stk_full_flag  = state_q.stk_full;
    assign stk_under_flag = state_q.stk_under;
    assign pc_act         = state_q.pc_act;
    assign vec_addr       = (state_q.pc_act == PC_VECTOR)
                          ? (state_q.vec_hi ? HI_VEC : LO_VEC) : '0;
endmodule

// File: rtl/rcs_checker.sv
module rcs_checker #(
    parameter int VEC_W = 21
) (
    input logic             clk,
    input logic             rst_n,
    input logic             por_ev,
    input logic             bor_ev,
    input logic             wdt_rst_ev,
    input logic             pin_sleep_ev,
    input logic             pin_run_ev,
    input logic             swrst_ev,
    input logic             stk_full_ev,
    input logic             stk_under_ev,
    input logic             wdt_wake_ev,
    input logic             int_wake_ev,
    input logic             wdt_clr_ev,
    input logic             sleep_ev,
    input logic             wr_en,
    input logic [7:0]       status,
    input logic             stk_full_flag,
    input logic [1:0]       pc_act,
    input logic [VEC_W-1:0] vec_addr
);
    logic above_wake;
    logic others_than_sleep;
    assign above_wake = por_ev | bor_ev | wdt_rst_ev | pin_sleep_ev | pin_run_ev
                      | swrst_ev | stk_full_ev | stk_under_ev;
    assign others_than_sleep = above_wake | wdt_wake_ev | int_wake_ev | wdt_clr_ev;

    // R1
    p_por_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        por_ev |=> (status == 8'h1C) && !stk_full_flag && (pc_act == 2'd1));

    // R3
    p_bor_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bor_ev && !por_ev) |=> (status[4:2] == 3'b111) && !status[0] && !status[7]
                                && (status[1] == $past(status[1])));

    // R5
    p_wdt_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_rst_ev && !por_ev && !bor_ev) |=> (status[3:2] == 2'b01)
                                              && (status[7] == $past(status[7])));

    // R6
    p_wdt_wake_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_wake_ev && !above_wake) |=> (pc_act == 2'd2) && (status[3:2] == 2'b00));

    // R7
    p_stk_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_full_flag && !por_ev) |=> stk_full_flag);

    // R11
    p_write_lost_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sleep_ev && !others_than_sleep) |=>
            (status[7] == $past(status[7])) && (status[4] == $past(status[4]))
            && (status[1:0] == $past(status[1:0])));

    // R8
    p_vec_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_act != 2'd3) |-> (vec_addr == '0));
endmodule

bind rcs_reset_cause rcs_checker #(.VEC_W(VEC_W)) u_rcs_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .por_ev         (por_ev),
    .bor_ev         (bor_ev),
    .wdt_rst_ev     (wdt_rst_ev),
    .pin_sleep_ev   (pin_sleep_ev),
    .pin_run_ev     (pin_run_ev),
    .swrst_ev       (swrst_ev),
    .stk_full_ev    (stk_full_ev),
    .stk_under_ev   (stk_under_ev),
    .wdt_wake_ev    (wdt_wake_ev),
    .int_wake_ev    (int_wake_ev),
    .wdt_clr_ev     (wdt_clr_ev),
    .sleep_ev       (sleep_ev),
    .wr_en          (wr_en),
    .status         (status),
    .stk_full_flag  (stk_full_flag),
    .pc_act         (pc_act),
    .vec_addr       (vec_addr)
);

// File: tb/test_rcs_reset_cause.sv
module test_rcs_reset_cause;
    localparam int CLK_PERIOD = 10;
    localparam int VEC_W      = 21;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [11:0]      ev = '0;
    logic             gie_set = 1'b0;
    logic             int_high = 1'b0;
    logic             wr_en = 1'b0;
    logic [7:0]       wr_data = '0;
    logic [7:0]       status;
    logic             stk_full_flag;
    logic             stk_under_flag;
    logic [1:0]       pc_act;
    logic [VEC_W-1:0] vec_addr;

    // expected state
    logic [7:0]       e_st;
    logic             e_sf, e_su;
    logic [1:0]       e_act;
    logic [VEC_W-1:0] e_vec;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rcs_reset_cause #(.VEC_W(VEC_W)) i_rcs_reset_cause (
        .clk            (clk),
        .rst_n          (rst_n),
        .por_ev         (ev[0]),
        .bor_ev         (ev[1]),
        .wdt_rst_ev     (ev[2]),
        .pin_sleep_ev   (ev[3]),
        .pin_run_ev     (ev[4]),
        .swrst_ev       (ev[5]),
        .stk_full_ev    (ev[6]),
        .stk_under_ev   (ev[7]),
        .wdt_wake_ev    (ev[8]),
        .int_wake_ev    (ev[9]),
        .wdt_clr_ev     (ev[10]),
        .sleep_ev       (ev[11]),
        .gie_set        (gie_set),
        .int_high       (int_high),
        .wr_en          (wr_en),
        .wr_data        (wr_data),
        .status         (status),
        .stk_full_flag  (stk_full_flag),
        .stk_under_flag (stk_under_flag),
        .pc_act         (pc_act),
        .vec_addr       (vec_addr)
    );

    function automatic string tag_of(logic [11:0] v, logic w, logic g);
        int n = $countones(v);
        if (n > 1) return "R12";
        if (n == 1 && w) return "R11";
        if (v[0]) return "R1";
        if (v[1]) return "R3";
        if (v[2] || v[3]) return "R5";
        if (v[4] || v[5]) return "R4";
        if (v[6] || v[7]) return "R7";
        if (v[8]) return "R6";
        if (v[9]) return g ? "R8" : "R6";
        if (v[10] || v[11]) return "R9";
        if (w) return "R10";
        return "R2";
    endfunction

    // Reference model from the requirements
    task automatic model_update();
        e_act = 2'd0;
        e_vec = '0;
        if (ev[0]) begin
            e_st = 8'h1C; e_sf = 1'b0; e_su = 1'b0; e_act = 2'd1;
        end else if (ev[1]) begin
            e_st[7] = 1'b0; e_st[4] = 1'b1; e_st[3] = 1'b1; e_st[2] = 1'b1;
            e_st[0] = 1'b0; e_act = 2'd1;
        end else if (ev[2]) begin
            e_st[3] = 1'b0; e_st[2] = 1'b1; e_act = 2'd1;
        end else if (ev[3]) begin
            e_st[7] = 1'b0; e_st[3] = 1'b1; e_st[2] = 1'b0; e_act = 2'd1;
        end else if (ev[4]) begin
            e_st[7] = 1'b0; e_act = 2'd1;
        end else if (ev[5]) begin
            e_st[7] = 1'b0; e_st[4] = 1'b0; e_act = 2'd1;
        end else if (ev[6]) begin
            e_st[7] = 1'b0; e_sf = 1'b1; e_act = 2'd1;
        end else if (ev[7]) begin
            e_st[7] = 1'b0; e_su = 1'b1; e_act = 2'd1;
        end else if (ev[8]) begin
            e_st[3] = 1'b0; e_st[2] = 1'b0; e_act = 2'd2;
        end else if (ev[9]) begin
            e_st[3] = 1'b0; e_st[2] = 1'b0;
            if (gie_set) begin
                e_act = 2'd3;
                e_vec = int_high ? 21'h08 : 21'h18;
            end else begin
                e_act = 2'd2;
            end
        end else if (ev[10]) begin
            e_st[3] = 1'b1; e_st[2] = 1'b1;
        end else if (ev[11]) begin
            e_st[3] = 1'b1; e_st[2] = 1'b0;
        end else if (wr_en) begin
            e_st[7] = wr_data[7]; e_st[4] = wr_data[4];
            e_st[1] = wr_data[1]; e_st[0] = wr_data[0];
        end
    endtask

    task automatic compare(string tag);
        n_checks++;
        if (status !== e_st || stk_full_flag !== e_sf || stk_under_flag !== e_su
            || pc_act !== e_act || vec_addr !== e_vec) begin
            n_fail++;
            $display("FAIL %s: got st=%h sf=%b su=%b act=%0d vec=%h, expected st=%h sf=%b su=%b act=%0d vec=%h",
                     tag, status, stk_full_flag, stk_under_flag, pc_act, vec_addr,
                     e_st, e_sf, e_su, e_act, e_vec);
        end
    endtask

    task automatic step(logic [11:0] v, logic w, logic [7:0] d, logic g, logic h);
        string tag;
        @(negedge clk);
        ev = v; wr_en = w; wr_data = d; gie_set = g; int_high = h;
        tag = tag_of(v, w, g);
        model_update();
        @(posedge clk);
        #1;
        compare(tag);
        @(negedge clk);
        ev = '0; wr_en = 1'b0;
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED_0042);
        e_st = 8'h1C; e_sf = 1'b0; e_su = 1'b0; e_act = 2'd0; e_vec = '0;
        repeat (3) @(posedge clk);
        #1;
        compare("R1");               // R1: reset state
        @(negedge clk);
        rst_n = 1'b1;

        // R10 / R2: write all ones, bits 6,5,3,2 ignore it
        step(12'h000, 1'b1, 8'hFF, 1'b0, 1'b0);
        step(12'h000, 1'b1, 8'h00, 1'b0, 1'b0);
        step(12'h000, 1'b0, 8'h00, 1'b0, 1'b0);
        step(12'h000, 1'b1, 8'h93, 1'b0, 1'b0);
        // R11: write lost when sleep instruction lands together
        step(12'h800, 1'b1, 8'h00, 1'b0, 1'b0);
        step(12'h020, 1'b1, 8'hFF, 1'b0, 1'b0);
        // R9
        step(12'h400, 1'b0, 8'h00, 1'b0, 1'b0);
        // R3, R4, R5, R7
        step(12'h002, 1'b0, 8'h00, 1'b0, 1'b0);
        step(12'h010, 1'b0, 8'h00, 1'b0, 1'b0);
        step(12'h008, 1'b0, 8'h00, 1'b0, 1'b0);
        step(12'h000, 1'b1, 8'h80, 1'b0, 1'b0);
        step(12'h004, 1'b0, 8'h00, 1'b0, 1'b0);
        step(12'h040, 1'b0, 8'h00, 1'b0, 1'b0);
        step(12'h080, 1'b0, 8'h00, 1'b0, 1'b0);
        // R6 / R8: wake-ups and vectors
        step(12'h100, 1'b0, 8'h00, 1'b0, 1'b0);
        step(12'h200, 1'b0, 8'h00, 1'b1, 1'b1);
        step(12'h200, 1'b0, 8'h00, 1'b1, 1'b0);
        step(12'h200, 1'b0, 8'h00, 1'b0, 1'b1);
        // R12: power-on beats brown-out; watchdog reset beats wake
        step(12'h003, 1'b0, 8'h00, 1'b0, 1'b0);
        step(12'h104, 1'b0, 8'h00, 1'b0, 1'b0);

        // Constrained random stream
        for (int i = 0; i < 3000; i++) begin
            logic [11:0] v;
            logic        w;
            int          k;
            v = '0; w = 1'b0;
            k = int'($urandom % 16);
            if (k < 11) v[k+1] = 1'b1;
            else if (k == 11) begin
                if ($urandom % 4 == 0) v[0] = 1'b1;
            end else if (k < 14) w = 1'b1;
            else if (k == 14) begin
                w = 1'b1; v[1 + ($urandom % 11)] = 1'b1;
            end else begin
                v[1 + ($urandom % 11)] = 1'b1;
                v[1 + ($urandom % 11)] = 1'b1;
            end
            step(v, w, 8'($urandom), 1'($urandom), 1'($urandom));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule